// File: doc/BRIEF.md
# Program Status Polling Read Path

This block sits in the read path of a page-programmable flash array. While the write sequencer reports that an internal program or erase cycle is running, reads do not return array contents. They return a status byte instead, so the host can tell when the cycle has finished. The host can use either of two methods.

- **Polled bit.** The top bit is the inverse of the top bit of the last loaded byte. During a chip erase it is the inverse of an erased byte's top bit, which is 0.
- **Toggle bit.** The bit below the top flips once per read access.

When the cycle ends, array data passes through unchanged.

The chip-enable and output-enable pins are active low and asynchronous to the clock. They pass through a synchronizer of `SYNC_STAGES` flops. A read access is the falling edge of output enable while chip enable is low, as seen after synchronization. The block expects `rst_n` to be asserted asynchronously and released synchronously by the surrounding reset logic.

Top module: `prog_poll_status`

## Requirements
- R1: When `ce_n` or `oe_n` is high, `rd_drive` is 0 and `rd_data` is all zeros.
- R2: When `busy` is 0 and both enables are low, `rd_drive` is 1 and `rd_data` equals `array_data`.
- R3: When `busy` is 1, `erase` is 0 and the output is driven, bit 7 of `rd_data` is the inverse of bit 7 of `last_data`.
- R4: When `busy` is 1, `erase` is 0 and the output is driven, bits 5..0 of `rd_data` equal bits 5..0 of `last_data`.
- R5: When `busy` and `erase` are both 1 and the output is driven, bit 7 of `rd_data` is 0 and bits 5..0 are all ones.
- R6: While `busy` is 1, each read access inverts bit 6 of `rd_data`. A read access is a high-to-low transition of `oe_n` with `ce_n` low. The new value is visible from `SYNC_STAGES`+1 clock edges after the transition. The first access of a busy period reads bit 6 as 1.
- R7: A high-to-low transition of `oe_n` while `ce_n` is high does not change the toggle state.
- R8: While `busy` is 0 the toggle state is held cleared, so it stops changing as soon as the cycle finishes. After reset it is also cleared.
- R9: Holding `oe_n` low for any number of cycles counts as one read access only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable pin, active low, asynchronous |
| oe_n | input | 1 | Output enable pin, active low, asynchronous |
| busy | input | 1 | Internal program or erase cycle in progress (from write sequencer) |
| erase | input | 1 | Running cycle is a chip erase (valid while busy) |
| last_data | input | DW | Last byte loaded by the host |
| array_data | input | DW | Data read from the array at the current address |
| rd_drive | output | 1 | Enable for the external data-bus drivers |
| rd_data | output | DW | Byte presented on the data bus |

## Verification
The hardest cases to reach from the ports involve the toggle state, which is never visible directly. Only bit 6 of a later read shows it. To check that an output-enable edge with chip enable high, or a long held read, left the toggle alone, the bench has to run a sequence of real read accesses. It predicts the expected bit from how many valid accesses it has issued in the current busy period, so a wrong toggle shows up as a broken alternation. Exhaustive 256-value sweeps of the loaded byte and the array byte cover the data bits.

// File: rtl/poll_pkg.sv
package poll_pkg;
  // output source selection for the read data mux
  typedef enum logic [1:0] {
    SRC_OFF    = 2'd0,
    SRC_ARRAY  = 2'd1,
    SRC_STATUS = 2'd2
  } poll_src_e;
endpackage

// File: rtl/poll_sync.sv
module poll_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb stg_d = din;
    end else begin : g_chain
      always_comb stg_d = {stg_q[STAGES-2:0], din};
    end
  endgenerate

  // pins are inactive high, so reset to all ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '1;
    else        stg_q <= stg_d;
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/poll_toggle.sv
module poll_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_s,
  input  logic oe_s,
  input  logic busy,
  output logic strobe,
  output logic tog
);
  logic oe_p_q;
  logic tog_d;
  logic tog_en;

  // one read access per falling edge of output enable under chip enable
  assign strobe = oe_p_q & ~oe_s & ~ce_s;

  always_comb begin
    tog_en = ~busy | strobe;
    tog_d  = busy ? ~tog : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_p_q <= 1'b1;
      tog    <= 1'b0;
    end else begin
      oe_p_q <= oe_s;
      if (tog_en) tog <= tog_d;
    end
  end

  // R6
  tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && strobe) |=> (tog != $past(tog)));
  // R9
  tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !strobe) |=> $stable(tog));
  // R8
  tog_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !tog);
  // R9
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
endmodule

// File: rtl/poll_mux.sv
module poll_mux
  import poll_pkg::*;
#(
  parameter int DW = 8
) (
  input  poll_src_e     sel,
  input  logic          erase,
  input  logic          tog,
  input  logic [DW-1:0] last_data,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] rd_data
);
  localparam int POLL_BIT = DW - 1;
  localparam int LOW_W    = DW - 2;

  logic [DW-1:0] status;

  always_comb begin
    if (erase) status = {1'b0, tog, {LOW_W{1'b1}}};
    else       status = {~last_data[POLL_BIT], tog, last_data[LOW_W-1:0]};
  end

  always_comb begin
    unique case (sel)
      SRC_ARRAY:  rd_data = array_data;
      SRC_STATUS: rd_data = status;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/prog_poll_status.sv
module prog_poll_status
  import poll_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          busy,
  input  logic          erase,
  input  logic [DW-1:0] last_data,
  input  logic [DW-1:0] array_data,
  output logic          rd_drive,
  output logic [DW-1:0] rd_data
);
  localparam int POLL_BIT = DW - 1;
  localparam int LOW_W    = DW - 2;

  logic [1:0] pins_s;
  logic       strobe;
  logic       tog;
  poll_src_e  sel;

  poll_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({ce_n, oe_n}),
    .dout (pins_s)
  );

  poll_toggle u_tog (
    .clk   (clk),
    .rst_n (rst_n),
    .ce_s  (pins_s[1]),
    .oe_s  (pins_s[0]),
    .busy  (busy),
    .strobe(strobe),
    .tog   (tog)
  );

  assign rd_drive = ~ce_n & ~oe_n;

  always_comb begin
    if (!rd_drive)  sel = SRC_OFF;
    else if (busy)  sel = SRC_STATUS;
    else            sel = SRC_ARRAY;
  end

  poll_mux #(.DW(DW)) u_mux (
    .sel       (sel),
    .erase     (erase),
    .tog       (tog),
    .last_data (last_data),
    .array_data(array_data),
    .rd_data   (rd_data)
  );

  // R1
  undriven_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |-> (rd_data == '0));
  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !busy) |-> (rd_data == array_data));
  // R3
  poll_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_drive && busy && !erase) |-> (rd_data[POLL_BIT] != last_data[POLL_BIT]));
  // R5
  erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_drive && busy && erase) |-> (!rd_data[POLL_BIT] && (&rd_data[LOW_W-1:0])));
endmodule

// File: tb/prog_poll_status_test.sv
module prog_poll_status_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ce_n, oe_n, busy, erase;
  logic [7:0] last_data, array_data;
  logic       rd_drive;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  prog_poll_status uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
    .busy(busy), .erase(erase), .last_data(last_data),
    .array_data(array_data), .rd_drive(rd_drive), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one read access; sample after the toggle update has settled
  task automatic do_read(output logic [7:0] d);
    ce_n = 1'b0;
    wait_neg(1);
    oe_n = 1'b0;
    wait_neg(5);
    d = rd_data;
    oe_n = 1'b1;
    wait_neg(4);
    ce_n = 1'b1;
    wait_neg(1);
  endtask

  function automatic logic [7:0] prog_status(input logic [7:0] ld, input logic t);
    return {~ld[7], t, ld[5:0]};
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    logic       exp_t;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; busy = 1'b0; erase = 1'b0;
    last_data = 8'h00; array_data = 8'h00;
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(2);
    // reset state, R1 and R8
    chk("R1 reset drive", {7'd0, rd_drive}, 8'h00);
    chk("R1 reset data", rd_data, 8'h00);
    busy = 1'b1; last_data = 8'h00;
    ce_n = 1'b0; wait_neg(1);
    chk("R8 toggle cleared after reset (no strobe yet)", rd_data, 8'h00);
    chk("R8 toggle cleared (pre-strobe oe high)", {7'd0, rd_drive}, 8'h00);
    ce_n = 1'b1; busy = 1'b0; wait_neg(2);

    // R2 sweep: pass-through while idle
    ce_n = 1'b0; oe_n = 1'b0;
    for (int v = 0; v < 256; v++) begin
      array_data = v[7:0];
      wait_neg(1);
      chk("R2 pass-through", rd_data, v[7:0]);
    end
    chk("R2 drive", {7'd0, rd_drive}, 8'h01);

    // R3/R4 sweep: status bits while programming (bit 6 masked)
    busy = 1'b1; erase = 1'b0;
    for (int v = 0; v < 256; v++) begin
      last_data = v[7:0];
      array_data = ~v[7:0];
      wait_neg(1);
      chk("R3 polled bit", rd_data & 8'h80, {~v[7], 7'd0});
      chk("R4 low bits", rd_data & 8'h3F, v[7:0] & 8'h3F);
    end

    // R5 sweep: erase polling value
    erase = 1'b1;
    for (int v = 0; v < 256; v += 17) begin
      last_data = v[7:0];
      wait_neg(1);
      chk("R5 erase status", rd_data & 8'hBF, 8'h3F);
    end
    erase = 1'b0;

    // R1: drive only with both enables low
    oe_n = 1'b1; wait_neg(1);
    chk("R1 oe high", rd_data, 8'h00);
    ce_n = 1'b1; oe_n = 1'b0; wait_neg(1);
    chk("R1 ce high", {7'd0, rd_drive}, 8'h00);
    chk("R1 ce high data", rd_data, 8'h00);
    oe_n = 1'b1;

    // new busy period: R8 clears toggle, then R6 alternation
    busy = 1'b0; wait_neg(3);
    busy = 1'b1; last_data = 8'h5A; wait_neg(1);
    exp_t = 1'b0;
    for (int k = 0; k < 6; k++) begin
      do_read(d);
      exp_t = ~exp_t;
      chk("R6 toggle sequence", d, prog_status(8'h5A, exp_t));
    end

    // R7: oe edge with ce high does not toggle
    ce_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      oe_n = 1'b0; wait_neg(5);
      chk("R1 during ce-high pulse", rd_data, 8'h00);
      oe_n = 1'b1; wait_neg(4);
    end
    do_read(d);
    exp_t = ~exp_t;
    chk("R7 no toggle with ce high", d, prog_status(8'h5A, exp_t));

    // R9: long held read counts once
    ce_n = 1'b0; wait_neg(1);
    oe_n = 1'b0; wait_neg(5);
    d = rd_data;
    wait_neg(20);
    d2 = rd_data;
    exp_t = ~exp_t;
    chk("R9 held read first", d, prog_status(8'h5A, exp_t));
    chk("R9 held read stable", d2, d);
    oe_n = 1'b1; wait_neg(4); ce_n = 1'b1; wait_neg(1);
    do_read(d);
    exp_t = ~exp_t;
    chk("R9 next read after hold", d, prog_status(8'h5A, exp_t));

    // R8: completion stops toggling and returns array data
    busy = 1'b0; array_data = 8'hC3; wait_neg(1);
    do_read(d);
    chk("R8 done read 1", d, 8'hC3);
    do_read(d);
    chk("R8 done read 2", d, 8'hC3);
    busy = 1'b1; last_data = 8'h81; wait_neg(1);
    do_read(d);
    chk("R6 first read of new busy period", d, prog_status(8'h81, 1'b1));
    busy = 1'b0;
    wait_neg(2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule